// File: doc/BRIEF.md
# Run-Length-Limited Pulse Polarity Scrambler

This block produces one polarity bit per pulse for a pulse burst. A 16-bit maximal-length linear feedback shift register supplies a pseudo-random sequence. Each bit goes into a short shift buffer, and the last stage of the buffer sets the phase of one transmitted pulse. While a burst is active the block counts how many identical bits in a row it has written into the head of the buffer. When that count reaches a programmable limit, the block discards the next generator bit. It writes the opposite polarity into the head stage in its place, so no polarity run is longer than the limit.

The generator advances once for every bit the block writes, including the bit it discards. A run-limit value of zero turns limiting off, and the raw pseudo-random sequence then passes through. A seed can be loaded at any time. Between bursts the generator and the run state hold their values, and the output reads as idle.

Top module: `rll_scrambler`

## Requirements
- R1: During and directly after reset, `pol_out` and `pol_valid` are 0 and the generator state equals the default seed 16'hACE1.
- R2: With `seed_load` high at a clock edge, the generator state becomes `seed_in`, or 16'hACE1 if `seed_in` is zero. This load takes priority over an advance in the same cycle.
- R3: The generator bit is state[0]. One advance shifts right: new state = {s[0]^s[2]^s[3]^s[5], s[15:1]}, which is the polynomial x^16+x^14+x^13+x^11+1.
- R4: In a cycle with `burst_en` high, one bit is written into the head stage. With the default depth of 2, that bit and `pol_valid`=1 appear on the output one edge after the write edge.
- R5: With `run_limit` L nonzero, when the last L bits written in the current burst are all equal, the next bit written is their inverse, so no output run within a burst exceeds L.
- R6: In a cycle where an inverted bit is written, the generator still advances, and its bit from that cycle is lost.
- R7: With `run_limit` = 0, no bit is inverted, and the output equals the raw generator sequence.
- R8: The first bit of every burst comes from the generator, and the run count restarts at 1 there, whatever the previous burst ended with.
- R9: With `burst_en` low, the generator and the run state hold their values. A zero with `pol_valid` = 0 enters the buffer, so the output reads 0 once the buffer drains.
- R10: A limit of 3 with a 16-pulse burst yields 16 valid bits with no run longer than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| burst_en | input | 1 | High for each cycle that produces a pulse polarity |
| seed_load | input | 1 | Loads the generator from `seed_in` |
| seed_in | input | 16 | Seed value; zero maps to 16'hACE1 |
| run_limit | input | 4 | Longest allowed run; 0 disables limiting; held steady during a burst |
| pol_out | output | 1 | Polarity bit of the current pulse |
| pol_valid | output | 1 | `pol_out` carries a burst bit |

## Verification
Three events can fall in the same cycle: inverting a bit, advancing the generator, and loading a seed. A limit of 1 makes every bit after the first an inverted one, so each cycle checks that the generator bit is discarded while its state still moves on. The bench also raises `seed_load` in the middle of a burst that is being limited, which makes the load and an advance compete in one cycle. A behavioural model compares `pol_out` and `pol_valid` on every clock, so a lost or duplicated generator step shows up as a mismatch in every later bit.

// File: rtl/rll_pkg.sv
package rll_pkg;
  localparam int unsigned LFSR_W = 16;
  // feedback taps for x^16+x^14+x^13+x^11+1 in right-shift form
  localparam logic [LFSR_W-1:0] TAP_MASK = 16'h002D;
  localparam logic [LFSR_W-1:0] SEED_DEFAULT = 16'hACE1;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {^(s & TAP_MASK), s[LFSR_W-1:1]};
  endfunction

  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
    return (s == '0) ? SEED_DEFAULT : s;
  endfunction
endpackage

// File: rtl/rll_lfsr.sv
module rll_lfsr
  import rll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic              bit_o
);
  logic [LFSR_W-1:0] state_q, state_d;
  logic              state_en;

  always_comb begin
    state_en = load | adv;
    state_d  = state_q;
    if (load)     state_d = seed_fix(seed);
    else if (adv) state_d = lfsr_step(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SEED_DEFAULT;
    else if (state_en) state_q <= state_d;
  end

  assign bit_o = state_q[0];

  assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(state_q));
  assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> state_q == $past(seed));
endmodule

// File: rtl/rll_run_guard.sv
module rll_run_guard #(
  parameter int unsigned LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_en,
  input  logic [LIM_W-1:0] run_limit,
  input  logic             gen_bit,
  output logic             head_bit,
  output logic             inject
);
  localparam logic [LIM_W-1:0] RUN_MAX = {LIM_W{1'b1}};

  logic [LIM_W-1:0] run_q, run_d;
  logic             prev_q, prev_d;
  logic             inb_q;
  logic             first;
  logic             limit_on;

  always_comb begin
    first    = burst_en & ~inb_q;
    limit_on = (run_limit != '0);
    inject   = burst_en & ~first & limit_on & (run_q >= run_limit);
    head_bit = inject ? ~prev_q : gen_bit;
    prev_d   = head_bit;
    if (first || inject || (head_bit != prev_q)) run_d = 'd1;
    else if (run_q == RUN_MAX)                   run_d = run_q;
    else                                         run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else if (burst_en) begin
      run_q  <= run_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inb_q <= 1'b0;
    else        inb_q <= burst_en;
  end

  assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && $past(burst_en) && $stable(run_limit) && run_limit != '0)
      |-> run_q <= run_limit);
  assert_inject_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> run_q == 'd1);
  assert_burst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && !inb_q) |=> (run_q == 'd1 && prev_q == $past(gen_bit)));
  assert_no_inject_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_limit == '0) |-> !inject);
endmodule

// File: rtl/rll_shift_buf.sv
module rll_shift_buf #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_vld,
  output logic out_bit,
  output logic out_vld
);
  logic [DEPTH-1:0] bit_q, bit_d;
  logic [DEPTH-1:0] vld_q, vld_d;

  always_comb begin
    bit_d[0] = in_bit & in_vld;
    vld_d[0] = in_vld;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_comb begin
      bit_d[i] = bit_q[i-1];
      vld_d[i] = vld_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      vld_q <= '0;
    end else begin
      bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  assign out_bit = bit_q[DEPTH-1];
  assign out_vld = vld_q[DEPTH-1];
endmodule

// File: rtl/rll_scrambler.sv
module rll_scrambler
  import rll_pkg::*;
#(
  parameter int unsigned LIM_W = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_en,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_in,
  input  logic [LIM_W-1:0]  run_limit,
  output logic              pol_out,
  output logic              pol_valid
);
  logic gen_bit;
  logic head_bit;
  logic inject;

  rll_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (burst_en),
    .load  (seed_load),
    .seed  (seed_in),
    .bit_o (gen_bit)
  );

  rll_run_guard #(.LIM_W(LIM_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .burst_en  (burst_en),
    .run_limit (run_limit),
    .gen_bit   (gen_bit),
    .head_bit  (head_bit),
    .inject    (inject)
  );

  rll_shift_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_bit  (head_bit),
    .in_vld  (burst_en),
    .out_bit (pol_out),
    .out_vld (pol_valid)
  );

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_valid |-> !pol_out);
  assert_inject_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> head_bit != gen_bit || $past(head_bit) != gen_bit);
endmodule

// File: tb/rll_scrambler_bench.sv
module rll_scrambler_bench;
  localparam int BD = 2;
  logic clk = 1'b0;
  logic rst_n;
  logic burst_en, seed_load;
  logic [15:0] seed_in;
  logic [3:0]  run_limit;
  logic pol_out, pol_valid;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  rll_scrambler u_rll_scrambler (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .seed_load(seed_load),
    .seed_in(seed_in), .run_limit(run_limit), .pol_out(pol_out), .pol_valid(pol_valid)
  );

  // behavioural reference
  logic [15:0] m_lfsr;
  int          m_run;
  logic        m_prev, m_inb;
  logic        exp_b[BD];
  logic        exp_v[BD];
  int          out_run;
  logic        out_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lfsr = 16'hACE1; m_run = 0; m_prev = 0; m_inb = 0;
      for (int i = 0; i < BD; i++) begin exp_b[i] = 0; exp_v[i] = 0; end
    end else begin
      logic bt;
      for (int i = BD-1; i > 0; i--) begin exp_b[i] = exp_b[i-1]; exp_v[i] = exp_v[i-1]; end
      if (burst_en) begin
        bt = m_lfsr[0];
        if (m_inb && run_limit != 0 && m_run >= run_limit) begin
          bt = ~m_prev; m_run = 1;
        end else if (!m_inb || bt != m_prev) m_run = 1;
        else if (m_run < 15) m_run = m_run + 1;
        exp_b[0] = bt; exp_v[0] = 1; m_prev = bt;
        m_lfsr = {m_lfsr[0]^m_lfsr[2]^m_lfsr[3]^m_lfsr[5], m_lfsr[15:1]};
      end else begin
        exp_b[0] = 0; exp_v[0] = 0;
      end
      if (seed_load) m_lfsr = (seed_in == 0) ? 16'hACE1 : seed_in;
      m_inb = burst_en;
    end
  end

  task automatic check(input string req, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, expv, $time);
    end
  endtask

  // compare on every falling edge once out of reset
  always @(negedge clk) if (rst_n) begin
    check({cur_req, " R4"}, pol_valid, exp_v[BD-1], "pol_valid");
    check({cur_req, " R3"}, pol_out, exp_b[BD-1], "pol_out");
    if (pol_valid) begin
      out_run = (out_run > 0 && pol_out == out_prev) ? out_run + 1 : 1;
      out_prev = pol_out;
      if (run_limit != 0) begin
        checks++;
        if (out_run > run_limit) begin
          errors++;
          $display("FAIL R5 run length: actual %0d expected <= %0d", out_run, run_limit);
        end
      end
    end else out_run = 0;
  end

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin burst_en = 1; @(negedge clk); end
    burst_en = 0;
  endtask

  task automatic idle(input int n);
    burst_en = 0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] s);
    seed_in = s; seed_load = 1; @(negedge clk); seed_load = 0;
  endtask

  initial begin
    int cnt;
    out_run = 0; out_prev = 0;
    rst_n = 0; burst_en = 0; seed_load = 0; seed_in = 0; run_limit = 3;
    #1;
    check("R1", pol_out, 1'b0, "reset pol_out");
    check("R1", pol_valid, 1'b0, "reset pol_valid");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1"; burst(20); idle(4);           // default seed
    cur_req = "R10"; load(16'h1234); run_limit = 3;
    cnt = 0;
    fork
      burst(16);
      begin
        @(negedge clk);
        for (int i = 0; i < 17; i++) begin if (pol_valid) cnt++; @(negedge clk); end
      end
    join
    check("R10", cnt == 16, 1'b1, "valid count 16");
    idle(3);
    cur_req = "R7"; run_limit = 0; idle(2); burst(60); idle(3);
    cur_req = "R6"; run_limit = 1; idle(2); burst(24); idle(3);
    run_limit = 0; idle(2); burst(30); idle(3);   // exposes lost advances
    cur_req = "R2"; load(16'h0000); run_limit = 2; idle(1); burst(25); idle(3);
    cur_req = "R8";
    for (int k = 0; k < 6; k++) begin burst(3 + k); idle(k % 3 + 1); end
    cur_req = "R9"; idle(6);
    check("R9", pol_out, 1'b0, "idle pol_out");
    cur_req = "R2"; run_limit = 2; burst_en = 1;
    for (int i = 0; i < 10; i++) @(negedge clk);
    seed_in = 16'hBEEF; seed_load = 1; @(negedge clk); seed_load = 0;
    for (int i = 0; i < 10; i++) @(negedge clk);
    idle(4);
    cur_req = "R5"; run_limit = 5; load(16'h8000); burst(80); idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule